// File: doc/BRIEF.md
# Byte-Width Priority Encoder

This block locates the highest set bit of a data word inside a chosen operand size of one, two, three or four bytes. The answer is not an absolute bit index: it is the distance of that bit below the top bit of the chosen size, as a 5-bit code. A per-bit enable vector removes unwanted bits before the search. Bits above the chosen size are also removed.

An output of 0 can mean two things: the top bit of the size is set, or nothing is set. A separate zero flag tells these cases apart. Both results are combinational. A load strobe also copies them into a position register. In the next cycle, that register can drive a normalising shift elsewhere in the datapath.

Top module: `prio_enc_bw`

## Requirements
- R1: The size select `width_sel` chooses the operand size: 2'b00 is 32 bits, 2'b01 is 8 bits, 2'b10 is 16 bits and 2'b11 is 24 bits. Input bits at or above the chosen size never change `pri_code` or `pri_zero`.
- R2: When at least one selected bit is set, `pri_code` equals (size − 1) minus the index of the highest selected set bit.
- R3: When the top bit of the chosen size is set and enabled, `pri_code` is 0 and `pri_zero` is 0.
- R4: When no selected bit is set, `pri_code` is 0 and `pri_zero` is 1. `pri_zero` is 0 in every other case.
- R5: A bit takes part in the search only where `bit_en` holds 1 at that position. A set data bit with `bit_en` at 0 has no effect on the outputs.
- R6: At a rising clock edge with `load_en` high, `pos_reg` takes {1'b0, `pri_code`} and `pos_zero` takes `pri_zero`. With `load_en` low, both registers hold their values.
- R7: While `rst_n` is low, `pos_reg` is 0 and `pos_zero` is 0.
- R8: Worked cases. In 32-bit mode, with bit 15 as the highest set bit, the code is 16. In 24-bit mode, with input 0x4B220000, the code is 2. In 16-bit mode, with bit 15 set, the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Load strobe for the position register |
| width_sel | input | 2 | Operand size select |
| data_in | input | 32 | Word to be searched |
| bit_en | input | 32 | Per-bit enable; 1 = bit takes part |
| pri_code | output | 5 | Distance of the highest set bit below the top of the size |
| pri_zero | output | 1 | High when no selected bit is set |
| pos_reg | output | 6 | Registered position field |
| pos_zero | output | 1 | Registered zero flag |

## Verification
Three cases all produce a code of 0: the top bit of the size is set, the word is empty, and the only set bits lie above the size or are disabled. Telling these apart at the ports is the hardest part. The stimulus sweeps every highest-bit position in every size, with random bits filled in below it. It adds patterns that place set bits only above the size, and patterns that set every bit but enable just one. The zero flag is then the only output that differs between these cases.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;

  // Operand size encodings seen on width_sel.
  typedef enum logic [1:0] {
    SZ_FULL  = 2'b00,
    SZ_ONE   = 2'b01,
    SZ_TWO   = 2'b10,
    SZ_THREE = 2'b11
  } size_sel_e;

  // Number of bytes chosen by a size code; code 0 means every byte.
  function automatic int bytes_of(input int sel, input int nbytes);
    return (sel == 0) ? nbytes : sel;
  endfunction

  // Index of the top bit of the chosen size.
  function automatic int top_of(input int sel, input int nbytes, input int bytew);
    return bytes_of(sel, nbytes) * bytew - 1;
  endfunction

  // Distance of a found bit below the top bit.
  function automatic int dist_below(input int top, input int idx);
    return top - idx;
  endfunction

endpackage

// File: rtl/prio_enc_window.sv
module prio_enc_window #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int SEL_W  = $clog2(NBYTES),
  localparam int CODE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  width_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] bit_en,
  output logic [DATA_W-1:0] sel_vec,
  output logic [CODE_W-1:0] top_idx,
  output logic              top_hit
);
  import prio_enc_pkg::*;

  logic [NBYTES-1:0] byte_on;
  logic [DATA_W-1:0] win;

  // One enable per byte lane, from the size code.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign byte_on[b] = (b < bytes_of(int'(width_sel), NBYTES));
    assign win[b*BYTE_W +: BYTE_W] = {BYTE_W{byte_on[b]}};
  end

  assign sel_vec = data_in & bit_en & win;
  assign top_idx = CODE_W'(top_of(int'(width_sel), NBYTES, BYTE_W));
  assign top_hit = sel_vec[top_idx];

  // R1: no selected bit lies above the top of the chosen size.
  a_r1_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec >> top_idx) <= 1);
  // R5: a disabled bit never reaches the search vector.
  a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec & ~bit_en) == '0);

endmodule

// File: rtl/prio_enc_msb.sv
module prio_enc_msb #(
  parameter int DATA_W = 32,
  localparam int CODE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] vec,
  output logic [CODE_W-1:0] idx,
  output logic              none
);

  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = 0; i < DATA_W; i++) begin
      if (vec[i]) begin
        idx  = CODE_W'(i);
        none = 1'b0;
      end
    end
  end

  // R2: the reported index is a set bit with nothing set above it.
  a_r2_msb_exact: assert property (@(posedge clk) disable iff (!rst_n)
    !none |-> ((vec >> idx) == 1));
  // R4: empty flag agrees with the vector.
  a_r4_none_empty: assert property (@(posedge clk) disable iff (!rst_n)
    none |-> (vec == '0));

endmodule

// File: rtl/prio_enc_posreg.sv
module prio_enc_posreg #(
  parameter int CODE_W = 5,
  localparam int POS_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] code,
  input  logic              zero,
  output logic [POS_W-1:0]  pos_q,
  output logic              zero_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      zero_q <= 1'b0;
    end else if (load_en) begin
      pos_q  <= {1'b0, code};
      zero_q <= zero;
    end
  end

  // R6: a load captures the previous cycle's result.
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (pos_q == {1'b0, $past(code)}) && (zero_q == $past(zero)));
  // R6: without a load the register holds.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(pos_q) && $stable(zero_q));

endmodule

// File: rtl/prio_enc_bw.sv
module prio_enc_bw #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int SEL_W  = $clog2(NBYTES),
  localparam int CODE_W = $clog2(DATA_W),
  localparam int POS_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [SEL_W-1:0]  width_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] bit_en,
  output logic [CODE_W-1:0] pri_code,
  output logic              pri_zero,
  output logic [POS_W-1:0]  pos_reg,
  output logic              pos_zero
);
  import prio_enc_pkg::*;

  logic [DATA_W-1:0] sel_vec;
  logic [CODE_W-1:0] top_idx;
  logic              top_hit;
  logic [CODE_W-1:0] msb_idx;
  logic              msb_none;

  prio_enc_window #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_window (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .data_in(data_in),
    .bit_en(bit_en), .sel_vec(sel_vec), .top_idx(top_idx), .top_hit(top_hit)
  );

  prio_enc_msb #(.DATA_W(DATA_W)) u_msb (
    .clk(clk), .rst_n(rst_n), .vec(sel_vec), .idx(msb_idx), .none(msb_none)
  );

  assign pri_zero = msb_none;
  assign pri_code = msb_none ? '0
                  : CODE_W'(dist_below(int'(top_idx), int'(msb_idx)));

  prio_enc_posreg #(.CODE_W(CODE_W)) u_posreg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .code(pri_code),
    .zero(pri_zero), .pos_q(pos_reg), .zero_q(pos_zero)
  );

  // R3: the top bit of the size gives code 0 with the flag low.
  a_r3_top_is_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    top_hit |-> (pri_code == '0) && !pri_zero);
  // R4: an empty selection gives code 0 with the flag high.
  a_r4_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec == '0) |-> pri_zero && (pri_code == '0));
  // R7: the register is cleared by reset.
  a_r7_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (pos_reg == '0) && !pos_zero);

endmodule

// File: tb/prio_enc_bw_bench.sv
module prio_enc_bw_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [1:0]  width_sel = 2'b00;
  logic [31:0] data_in = '0;
  logic [31:0] bit_en = '1;
  logic [4:0]  pri_code;
  logic        pri_zero;
  logic [5:0]  pos_reg;
  logic        pos_zero;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_enc_bw u_prio_enc_bw (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .width_sel(width_sel),
    .data_in(data_in), .bit_en(bit_en), .pri_code(pri_code),
    .pri_zero(pri_zero), .pos_reg(pos_reg), .pos_zero(pos_zero)
  );

  // Reference: scan downward from the top of the chosen size.
  function automatic int ref_code(input logic [1:0] w, input logic [31:0] d,
                                  input logic [31:0] m);
    int n = (w == 2'b00) ? 32 : 8 * int'(w);
    logic [31:0] v = d & m;
    for (int k = n - 1; k >= 0; k--) if (v[k]) return n - 1 - k;
    return 0;
  endfunction

  function automatic bit ref_zero(input logic [1:0] w, input logic [31:0] d,
                                  input logic [31:0] m);
    int n = (w == 2'b00) ? 32 : 8 * int'(w);
    logic [31:0] v = d & m;
    for (int k = 0; k < n; k++) if (v[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] w, input logic [31:0] d,
                       input logic [31:0] m, input string req);
    int ec;
    bit ez;
    @(negedge clk);
    width_sel = w; data_in = d; bit_en = m;
    #1;
    ec = ref_code(w, d, m);
    ez = ref_zero(w, d, m);
    check(pri_code == 5'(ec), req, int'(pri_code), ec);
    check(pri_zero == ez, {req, " zero"}, int'(pri_zero), int'(ez));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(pos_reg == 6'd0, "R7 pos_reg", int'(pos_reg), 0);
    check(pos_zero == 1'b0, "R7 pos_zero", int'(pos_zero), 0);
    rst_n = 1'b1;

    // R8: worked cases
    apply(2'b00, 32'h0000_8000, '1, "R8 32b bit15");
    check(pri_code == 5'd16, "R8 code16", int'(pri_code), 16);
    apply(2'b11, 32'h4B22_0000, '1, "R8 24b example");
    check(pri_code == 5'd2, "R8 code2", int'(pri_code), 2);
    apply(2'b10, 32'h0000_8001, '1, "R3 16b top");
    check(pri_code == 5'd0 && !pri_zero, "R3 top set", int'(pri_code), 0);

    // R1 R2: every highest-bit position in every size, random lower fill
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 32; p++) begin
        logic [31:0] low = (p == 0) ? 32'd0 : ($urandom & ((32'd1 << p) - 1));
        apply(2'(w), (32'd1 << p) | low, '1, "R2 sweep");
      end
    end

    // R4: empty word in each size; R1: only bits above the size set
    for (int w = 0; w < 4; w++) apply(2'(w), 32'd0, '1, "R4 empty");
    apply(2'b01, 32'hFFFF_FF00, '1, "R1 above 8b");
    check(pri_zero == 1'b1, "R1 above 8b flag", int'(pri_zero), 1);
    apply(2'b10, 32'hFFFF_0000, '1, "R1 above 16b");
    apply(2'b11, 32'hFF00_0000, '1, "R1 above 24b");

    // R5: all data set, a single enabled bit
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 32; p++) apply(2'(w), '1, 32'd1 << p, "R5 one enable");
    end
    apply(2'b00, '1, 32'd0, "R5 none enabled");
    check(pri_zero == 1'b1, "R5 none enabled flag", int'(pri_zero), 1);

    // Random mix of sizes, data and enables
    for (int i = 0; i < 3000; i++)
      apply(2'($urandom), $urandom, $urandom | $urandom, "R2 random");

    // R6: load and hold
    @(negedge clk);
    width_sel = 2'b00; data_in = 32'h0000_0008; bit_en = '1; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    check(pos_reg == 6'd28, "R6 load code", int'(pos_reg), 28);
    check(pos_zero == 1'b0, "R6 load flag", int'(pos_zero), 0);
    data_in = 32'h8000_0000;
    @(negedge clk);
    check(pos_reg == 6'd28, "R6 hold", int'(pos_reg), 28);
    data_in = 32'd0; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    check(pos_reg == 6'd0, "R6 load empty code", int'(pos_reg), 0);
    check(pos_zero == 1'b1, "R6 load empty flag", int'(pos_zero), 1);
    width_sel = 2'b11; data_in = 32'h0000_0100;
    @(negedge clk);
    check(pos_zero == 1'b1 && pos_reg == 6'd0, "R6 hold empty", int'(pos_reg), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule